// File: doc/BRIEF.md
# Byte-Coded Microsequencer

This block is a small microprogrammed controller. Each clock it reads one eight-bit instruction from an external microcode store, addressed by its program counter. An instruction does one of two things. It can drive a bank of seven registered control lines. It can also test one of eight condition inputs and jump on the result. A fixed polarity mask, set by a parameter, lets any control line be active low. The operand names the signals to assert as active-high bits, and the block XORs it with the mask before it drives the pins. One operand byte can assert several signals at once.

The store answers combinationally: `rom_data` must hold the word at `rom_addr` within the same cycle. As a result every clock retires exactly one instruction and there are no stall cycles. A timed loop therefore costs one clock per instruction. For example, a sample loop paced by a clock eight times slower fits in eight instructions. Every port is a plain level signal with no valid/ready handshake, because the store never refuses a fetch and the condition lines are status levels. The program counter is split into a 3-bit word offset and an upper page register. Branches reach only the eight words of the current page. Sequential flow carries from the offset into the page register.

Top module: `bytecode_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `rom_addr` to 0 and sets `ctrl_out` to `POL_MASK`, which is every line at its inactive level.
- R2: A word with bit 7 = 0 is a drive instruction. On the next edge `ctrl_out` becomes `rom_data[6:0] ^ POL_MASK`, and several operand bits may be set together.
- R3: A word with bit 7 = 1 is a branch instruction. It leaves `ctrl_out` unchanged, taken or not.
- R4: A drive instruction advances `rom_addr` by exactly one.
- R5: A branch with bit 6 = 0 is taken when `cond_in[rom_data[5:3]]` is 0.
- R6: A branch with bit 6 = 1 is taken when `cond_in[rom_data[5:3]]` is 1.
- R7: A branch that is not taken advances `rom_addr` by exactly one.
- R8: A taken branch loads `rom_data[2:0]` into the low three address bits and keeps the upper (page) bits. Sequential advance carries from offset 7 into the page, and the highest address wraps to 0.
- R9: Exactly one instruction retires per clock, so a loop of eight instructions repeats its address sequence every eight clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_in | input | 8 | Condition inputs, selected by branch bits 5:3 |
| rom_addr | output | ADDR_W | Microcode store address (program counter) |
| rom_data | input | 8 | Instruction word at `rom_addr`, valid in the same cycle |
| ctrl_out | output | 7 | Registered control lines after the polarity mask |

## Verification
The assertions take for granted that `rom_data` is a known, settled function of `rom_addr` at every rising edge. They also take for granted that `cond_in` holds still across each edge, since both feed the next-state decision combinationally. The stimulus keeps within this. The bench's behavioural store is filled completely before reset is released and is only rewritten while reset is held. Condition inputs change only at falling edges, and only while reset is asserted.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int INSTR_W = 8;
  localparam int OUT_W   = INSTR_W - 1;
  localparam int OFF_W   = 3;
  localparam int SEL_W   = 3;
  localparam int COND_N  = 1 << SEL_W;

  typedef enum logic {
    OP_DRIVE  = 1'b0,
    OP_BRANCH = 1'b1
  } op_kind_e;

  typedef struct packed {
    op_kind_e           kind;
    logic               want_one;
    logic [SEL_W-1:0]   sel;
    logic [OFF_W-1:0]   tgt;
    logic [OUT_W-1:0]   operand;
  } uinstr_t;
endpackage

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output uinstr_t            dec
);
  always_comb begin
    dec.kind     = op_kind_e'(instr[INSTR_W-1]);
    dec.want_one = instr[INSTR_W-2];
    dec.sel      = instr[OFF_W+SEL_W-1:OFF_W];
    dec.tgt      = instr[OFF_W-1:0];
    dec.operand  = instr[OUT_W-1:0];
  end
endmodule

// File: rtl/useq_cond_select.sv
module useq_cond_select
  import useq_pkg::*;
(
  input  logic [COND_N-1:0] cond,
  input  logic [SEL_W-1:0]  sel,
  input  logic              want_one,
  input  logic              is_branch,
  output logic              taken
);
  logic [COND_N-1:0] hit;
  logic              cond_bit;

  for (genvar g = 0; g < COND_N; g++) begin : g_hit
    assign hit[g] = (sel == SEL_W'(g)) & cond[g];
  end

  assign cond_bit = |hit;
  assign taken    = is_branch & (cond_bit == want_one);
endmodule

// File: rtl/useq_pc.sv
module useq_pc
  import useq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jump,
  input  logic [OFF_W-1:0]  tgt,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [OFF_W-1:0]  off_inc;
  logic              carry;

  always_comb begin
    {carry, off_inc} = {1'b0, off_q} + (OFF_W+1)'(1);
    if (jump) begin
      off_d  = tgt;
      page_d = page_q;
    end else begin
      off_d  = off_inc;
      page_d = page_q + PAGE_W'(carry);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      off_q  <= '0;
    end else begin
      page_q <= page_d;
      off_q  <= off_d;
    end
  end

  assign addr = {page_q, off_q};

  // R8: a jump never leaves the current page
  a_r8_page_kept: assert property (@(posedge clk) disable iff (rst)
    jump |=> page_q == $past(page_q));

  // R8: sequential flow from offset 7 lands on offset 0
  a_r8_offset_wrap: assert property (@(posedge clk) disable iff (rst)
    (!jump && off_q == '1) |=> off_q == '0);
endmodule

// File: rtl/useq_outreg.sv
module useq_outreg
  import useq_pkg::*;
#(
  parameter logic [OUT_W-1:0] POL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OUT_W-1:0] operand,
  output logic [OUT_W-1:0] lines
);
  for (genvar b = 0; b < OUT_W; b++) begin : g_line
    logic q;
    always_ff @(posedge clk) begin
      if (rst)       q <= POL_MASK[b];
      else if (load) q <= operand[b] ^ POL_MASK[b];
    end
    assign lines[b] = q;
  end

  // R3: lines hold whenever no drive instruction retires
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(lines));
endmodule

// File: rtl/bytecode_sequencer.sv
module bytecode_sequencer
  import useq_pkg::*;
#(
  parameter int               ADDR_W   = 6,
  parameter logic [OUT_W-1:0] POL_MASK = 7'h45
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [COND_N-1:0]   cond_in,
  output logic [ADDR_W-1:0]   rom_addr,
  input  logic [INSTR_W-1:0]  rom_data,
  output logic [OUT_W-1:0]    ctrl_out
);
  uinstr_t dec;
  logic    is_branch;
  logic    taken;

  useq_decode u_decode (
    .instr (rom_data),
    .dec   (dec)
  );

  assign is_branch = (dec.kind == OP_BRANCH);

  useq_cond_select u_cond (
    .cond      (cond_in),
    .sel       (dec.sel),
    .want_one  (dec.want_one),
    .is_branch (is_branch),
    .taken     (taken)
  );

  useq_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .jump (taken),
    .tgt  (dec.tgt),
    .addr (rom_addr)
  );

  useq_outreg #(.POL_MASK(POL_MASK)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (!is_branch),
    .operand (dec.operand),
    .lines   (ctrl_out)
  );

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rom_addr == '0 && ctrl_out == POL_MASK));

  // R2: drive instruction lands masked operand on the lines
  a_r2_drive: assert property (@(posedge clk) disable iff (rst)
    !rom_data[INSTR_W-1] |=> ctrl_out == ($past(rom_data[OUT_W-1:0]) ^ POL_MASK));

  // R4: drive instruction steps the address by one
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    !rom_data[INSTR_W-1] |=> rom_addr == ADDR_W'($past(rom_addr) + 1'b1));

  // R3: branches never touch the lines
  a_r3_branch_hold: assert property (@(posedge clk) disable iff (rst)
    rom_data[INSTR_W-1] |=> $stable(ctrl_out));

  // R5, R6: a matching condition loads the in-page target
  a_r5_r6_taken: assert property (@(posedge clk) disable iff (rst)
    (rom_data[INSTR_W-1] && cond_in[rom_data[5:3]] == rom_data[6])
      |=> rom_addr == {$past(rom_addr[ADDR_W-1:OFF_W]), $past(rom_data[OFF_W-1:0])});

  // R7: a mismatching condition falls through
  a_r7_fall_through: assert property (@(posedge clk) disable iff (rst)
    (rom_data[INSTR_W-1] && cond_in[rom_data[5:3]] != rom_data[6])
      |=> rom_addr == ADDR_W'($past(rom_addr) + 1'b1));
endmodule

// File: tb/bytecode_sequencer_test.sv
`timescale 1ns/1ps
module bytecode_sequencer_test;
  localparam int         AW   = 6;
  localparam int         WORDS = 1 << AW;
  localparam logic [6:0] MASK = 7'h45;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    cond_in = '0;
  logic [AW-1:0] rom_addr;
  logic [7:0]    rom_data;
  logic [6:0]    ctrl_out;
  logic [7:0]    rom [WORDS];

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  assign rom_data = rom[rom_addr];

  bytecode_sequencer #(.ADDR_W(AW), .POL_MASK(MASK)) uut (
    .clk      (clk),
    .rst      (rst),
    .cond_in  (cond_in),
    .rom_addr (rom_addr),
    .rom_data (rom_data),
    .ctrl_out (ctrl_out)
  );

  // scoreboard queues
  logic [AW-1:0] exp_a [$];
  logic [6:0]    exp_o [$];
  string         exp_t [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: one retired instruction per clock, sampled after the edge
  always @(posedge clk) begin
    #1;
    if (exp_a.size() > 0) begin
      logic [AW-1:0] a;
      logic [6:0]    o;
      string         t;
      a = exp_a.pop_front();
      o = exp_o.pop_front();
      t = exp_t.pop_front();
      check(rom_addr == a, t, "rom_addr", 16'(rom_addr), 16'(a));
      check(ctrl_out == o, t, "ctrl_out", 16'(ctrl_out), 16'(o));
    end
  end

  // driver: reset, check R1, then predict n instructions from the spec
  task automatic run(input int n, input logic [7:0] cond);
    logic [AW-1:0] pc;
    logic [6:0]    out;
    @(negedge clk);
    rst     = 1'b1;
    cond_in = cond;
    @(negedge clk);
    check(rom_addr == '0, "R1", "reset addr", 16'(rom_addr), 16'h0);
    check(ctrl_out == MASK, "R1", "reset lines", 16'(ctrl_out), 16'(MASK));
    pc  = '0;
    out = MASK;
    for (int i = 0; i < n; i++) begin
      logic [7:0]    w;
      logic [AW-1:0] np;
      string         t;
      w = rom[pc];
      if (!w[7]) begin
        out = w[6:0] ^ MASK;
        np  = pc + 1'b1;
        t   = (np[2:0] == 3'd0) ? "R8,R4 page carry" : "R2,R4 drive";
      end else if (cond[w[5:3]] == w[6]) begin
        np = {pc[AW-1:3], w[2:0]};
        t  = w[6] ? "R6,R3,R8 taken-on-1" : "R5,R3,R8 taken-on-0";
      end else begin
        np = pc + 1'b1;
        t  = "R7,R3 fall-through";
      end
      pc = np;
      exp_a.push_back(pc);
      exp_o.push_back(out);
      exp_t.push_back(t);
    end
    rst = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // mixed program: drives and branches of both polarities on all pages
    for (int i = 0; i < WORDS; i++) begin
      logic [7:0] w;
      if (i % 3 == 2) w = {1'b1, 1'((i >> 1) & 1), 3'(i * 3 + 1), 3'((i * 5) % 8)};
      else            w = {1'b0, 7'(i * 37 + 11)};
      rom[i] = w;
    end
    repeat (3) @(negedge clk);
    run(100, 8'h00);
    run(100, 8'hFF);
    run(100, 8'hA5);
    run(100, 8'h3C);

    // straight-line drives: page carries and wrap of the top address (R8)
    for (int i = 0; i < WORDS; i++) rom[i] = {1'b0, 7'(i * 13 + 5)};
    rom[9] = 8'h7F;  // every operand bit at once (R2)
    run(WORDS + 6, 8'h00);

    // eight-instruction loop on page 1 (R9)
    for (int i = 0; i < WORDS; i++) rom[i] = {1'b0, 7'(i)};
    rom[15] = {1'b1, 1'b0, 3'd2, 3'd0};  // branch-on-0 of cond 2 to offset 0
    @(negedge clk);
    cond_in = 8'h00;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    begin
      logic [AW-1:0] a0;
      logic [AW-1:0] a1;
      logic [6:0]    o0;
      a0 = rom_addr;
      o0 = ctrl_out;
      @(posedge clk); #1;
      a1 = rom_addr;
      check(a1 != a0, "R9", "address moves each clock", 16'(a1), 16'(a0 + 1'b1));
      repeat (7) @(posedge clk); #1;
      check(rom_addr == a0, "R9", "period-8 address", 16'(rom_addr), 16'(a0));
      check(ctrl_out == o0, "R9", "period-8 lines", 16'(ctrl_out), 16'(o0));
      check(rom_addr[AW-1:3] == 3'd1, "R9", "loop page", 16'(rom_addr[AW-1:3]), 16'd1);
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule